// File: doc/BRIEF.md
# In-Order Retirement Queue with Precise Traps

This block keeps the speculative results of instructions that may finish execution in any order, and hands them to the architected register file strictly in program order. A dispatch stage places one instruction per cycle at the tail of a circular queue. It records the program counter and the architected destination register, and receives the slot index back. That index is the rename tag that later consumers and the execution units use to name the result.

Execution units write a result value and a fault flag into any live slot by tag. Consumers may look up a slot by tag at any time, which gives them results that have not yet retired. Each cycle the oldest slot is examined. If it has finished cleanly, its value is written to the architected register file and the slot is freed. If it has finished with a fault, no architected state changes. Instead a one-cycle trap request carrying its program counter is raised, and the whole queue, including every younger slot, is emptied in that same cycle. Several live slots may name the same architected register. Because retirement is ordered, the youngest of them writes last.

Top module: `rob_core`

## Requirements
- R1: While reset is asserted and after it is released, the queue is empty: dispatch is accepted, no register write and no trap is requested, and no tag reports a ready result.
- R2: Accepted dispatches receive consecutive tags starting at 0 and wrapping from DEPTH-1 back to 0. The offered tag is the tag the next accepted dispatch will take.
- R3: When DEPTH slots are live and the oldest one cannot retire, dispatch is refused and a dispatch request has no effect on the queue.
- R4: A writeback to a live tag stores its value and fault flag and marks the slot finished. From the next cycle a lookup of that tag reports ready with that value. A lookup of a slot not yet written reports not ready.
- R5: Only the oldest slot can retire. A finished younger slot produces neither a register write nor a trap while an older slot is unfinished.
- R6: A finished, fault-free oldest slot produces a register write of its destination register and value in the cycle it is seen, and the slot is freed at the next edge. At most one retirement occurs per cycle.
- R7: A finished, faulting oldest slot produces a one-cycle trap request with its program counter and no register write. At the next edge every slot is discarded and the next tag offered is 0.
- R8: In the cycle a trap is requested, dispatch is refused, whatever the queue occupancy.
- R9: When the queue is full and the oldest slot retires cleanly in the same cycle, a dispatch is accepted in that cycle into the freed position.
- R10: Live slots that share a destination register retire one by one in allocation order, each writing its own value.
- R11: A writeback whose tag names no live slot is ignored. A slot later allocated at that tag starts out unfinished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid_i | input | 1 | Dispatch request |
| disp_pc_i | input | XLEN | Program counter of the dispatched instruction |
| disp_areg_i | input | AREG_W | Architected destination register |
| disp_ready_o | output | 1 | Dispatch is accepted this cycle |
| disp_tag_o | output | IDX_W | Tag given to a dispatch accepted this cycle |
| wb_valid_i | input | 1 | Writeback request |
| wb_tag_i | input | IDX_W | Tag of the slot written |
| wb_value_i | input | XLEN | Result value |
| wb_fault_i | input | 1 | Instruction raised a fault |
| src_tag_i | input | IDX_W | Tag looked up by a consumer |
| src_value_o | output | XLEN | Value held at the looked-up tag |
| src_ready_o | output | 1 | Looked-up slot is live and finished |
| arf_we_o | output | 1 | Architected register write (clean retirement) |
| arf_areg_o | output | AREG_W | Register written |
| arf_value_o | output | XLEN | Value written |
| trap_o | output | 1 | Trap request pulse |
| trap_pc_o | output | XLEN | Program counter of the faulting instruction |

## Verification
The checker rebuilds occupancy and the expected next tag from the port handshakes alone. It therefore assumes that a dispatch counts exactly when disp_valid_i and disp_ready_o are both high, and that every retirement shows up on arf_we_o or trap_o. It also assumes the control inputs are known (not X) whenever reset is released. The stimulus changes inputs only on the falling clock edge and holds them stable through the rising edge. Writeback tags are aimed mostly at live slots, with some deliberately aimed at free slots to exercise the ignore rule. Faults are injected rarely enough that the queue often reaches full before a trap empties it.

// File: rtl/rob_pkg.sv
`timescale 1ns/1ps
package rob_pkg;

  // Decision taken on the oldest slot in a cycle
  typedef enum logic [1:0] {
    CMT_IDLE   = 2'd0,
    CMT_RETIRE = 2'd1,
    CMT_TRAP   = 2'd2
  } cmt_e;

endpackage

// File: rtl/rob_ptr_ctrl.sv
`timescale 1ns/1ps
module rob_ptr_ctrl #(
  parameter int DEPTH = 8,
  parameter int IDX_W = 3,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_i,
  input  logic             retire_i,
  input  logic             flush_i,
  output logic [IDX_W-1:0] head_o,
  output logic [IDX_W-1:0] tail_o,
  output logic             full_o
);

  logic [IDX_W-1:0] head_q, head_n;
  logic [IDX_W-1:0] tail_q, tail_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             upd_en;

  function automatic logic [IDX_W-1:0] wrap_inc(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign upd_en = alloc_i | retire_i | flush_i;

  always_comb begin
    head_n = head_q;
    tail_n = tail_q;
    cnt_n  = cnt_q;
    if (flush_i) begin
      head_n = '0;
      tail_n = '0;
      cnt_n  = '0;
    end else begin
      if (retire_i) head_n = wrap_inc(head_q);
      if (alloc_i)  tail_n = wrap_inc(tail_q);
      cnt_n = cnt_q + CNT_W'(alloc_i) - CNT_W'(retire_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else if (upd_en) begin
      head_q <= head_n;
      tail_q <= tail_n;
      cnt_q  <= cnt_n;
    end
  end

  assign head_o = head_q;
  assign tail_o = tail_q;
  assign full_o = (cnt_q == CNT_W'(DEPTH));

endmodule

// File: rtl/rob_entry_array.sv
`timescale 1ns/1ps
module rob_entry_array #(
  parameter int DEPTH  = 8,
  parameter int IDX_W  = 3,
  parameter int XLEN   = 32,
  parameter int AREG_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic              alloc_i,
  input  logic [IDX_W-1:0]  alloc_idx_i,
  input  logic [XLEN-1:0]   alloc_pc_i,
  input  logic [AREG_W-1:0] alloc_areg_i,
  input  logic              wb_en_i,
  input  logic [IDX_W-1:0]  wb_idx_i,
  input  logic [XLEN-1:0]   wb_value_i,
  input  logic              wb_fault_i,
  input  logic              retire_i,
  input  logic [IDX_W-1:0]  head_idx_i,
  input  logic [IDX_W-1:0]  src_idx_i,
  output logic              head_valid_o,
  output logic              head_done_o,
  output logic              head_fault_o,
  output logic [XLEN-1:0]   head_pc_o,
  output logic [AREG_W-1:0] head_areg_o,
  output logic [XLEN-1:0]   head_value_o,
  output logic [XLEN-1:0]   src_value_o,
  output logic              src_ready_o
);

  logic [DEPTH-1:0]  valid_w;
  logic [DEPTH-1:0]  done_w;
  logic [DEPTH-1:0]  fault_w;
  logic [XLEN-1:0]   pc_w   [DEPTH];
  logic [XLEN-1:0]   val_w  [DEPTH];
  logic [AREG_W-1:0] areg_w [DEPTH];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
    logic              v_q, v_n, d_q, d_n, f_q, f_n;
    logic [XLEN-1:0]   pc_q, pc_n, val_q, val_n;
    logic [AREG_W-1:0] ar_q, ar_n;
    logic              wb_hit, alloc_hit, ret_hit, ctrl_en, data_en;

    assign wb_hit    = wb_en_i  && (wb_idx_i    == IDX_W'(gi)) && v_q;
    assign alloc_hit = alloc_i  && (alloc_idx_i == IDX_W'(gi));
    assign ret_hit   = retire_i && (head_idx_i  == IDX_W'(gi));
    assign ctrl_en   = flush_i | wb_hit | alloc_hit | ret_hit;
    assign data_en   = !flush_i && (wb_hit || alloc_hit);

    // writeback, then retirement, then allocation; flush overrides all
    always_comb begin
      v_n   = v_q;
      d_n   = d_q;
      f_n   = f_q;
      pc_n  = pc_q;
      ar_n  = ar_q;
      val_n = val_q;
      if (flush_i) begin
        v_n = 1'b0;
        d_n = 1'b0;
        f_n = 1'b0;
      end else begin
        if (wb_hit) begin
          val_n = wb_value_i;
          f_n   = wb_fault_i;
          d_n   = 1'b1;
        end
        if (ret_hit) v_n = 1'b0;
        if (alloc_hit) begin
          v_n  = 1'b1;
          d_n  = 1'b0;
          f_n  = 1'b0;
          pc_n = alloc_pc_i;
          ar_n = alloc_areg_i;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        d_q <= 1'b0;
        f_q <= 1'b0;
      end else if (ctrl_en) begin
        v_q <= v_n;
        d_q <= d_n;
        f_q <= f_n;
      end
    end

    always_ff @(posedge clk) begin
      if (data_en) begin
        pc_q  <= pc_n;
        ar_q  <= ar_n;
        val_q <= val_n;
      end
    end

    assign valid_w[gi] = v_q;
    assign done_w[gi]  = d_q;
    assign fault_w[gi] = f_q;
    assign pc_w[gi]    = pc_q;
    assign val_w[gi]   = val_q;
    assign areg_w[gi]  = ar_q;
  end

  assign head_valid_o = valid_w[head_idx_i];
  assign head_done_o  = done_w[head_idx_i];
  assign head_fault_o = fault_w[head_idx_i];
  assign head_pc_o    = pc_w[head_idx_i];
  assign head_areg_o  = areg_w[head_idx_i];
  assign head_value_o = val_w[head_idx_i];

  assign src_value_o  = val_w[src_idx_i];
  assign src_ready_o  = valid_w[src_idx_i] & done_w[src_idx_i];

endmodule

// File: rtl/rob_commit_unit.sv
`timescale 1ns/1ps
module rob_commit_unit
  import rob_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int AREG_W = 5
) (
  input  logic              head_valid_i,
  input  logic              head_done_i,
  input  logic              head_fault_i,
  input  logic [XLEN-1:0]   head_pc_i,
  input  logic [AREG_W-1:0] head_areg_i,
  input  logic [XLEN-1:0]   head_value_i,
  output cmt_e              act_o,
  output logic              arf_we_o,
  output logic [AREG_W-1:0] arf_areg_o,
  output logic [XLEN-1:0]   arf_value_o,
  output logic              trap_o,
  output logic [XLEN-1:0]   trap_pc_o
);

  always_comb begin
    act_o = CMT_IDLE;
    if (head_valid_i && head_done_i) begin
      act_o = head_fault_i ? CMT_TRAP : CMT_RETIRE;
    end
  end

  assign arf_we_o    = (act_o == CMT_RETIRE);
  assign arf_areg_o  = head_areg_i;
  assign arf_value_o = head_value_i;
  assign trap_o      = (act_o == CMT_TRAP);
  assign trap_pc_o   = head_pc_i;

endmodule

// File: rtl/rob_core.sv
`timescale 1ns/1ps
module rob_core
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int XLEN   = 32,
  parameter int AREG_W = 5,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              disp_valid_i,
  input  logic [XLEN-1:0]   disp_pc_i,
  input  logic [AREG_W-1:0] disp_areg_i,
  output logic              disp_ready_o,
  output logic [IDX_W-1:0]  disp_tag_o,
  input  logic              wb_valid_i,
  input  logic [IDX_W-1:0]  wb_tag_i,
  input  logic [XLEN-1:0]   wb_value_i,
  input  logic              wb_fault_i,
  input  logic [IDX_W-1:0]  src_tag_i,
  output logic [XLEN-1:0]   src_value_o,
  output logic              src_ready_o,
  output logic              arf_we_o,
  output logic [AREG_W-1:0] arf_areg_o,
  output logic [XLEN-1:0]   arf_value_o,
  output logic              trap_o,
  output logic [XLEN-1:0]   trap_pc_o
);

  logic [IDX_W-1:0]  head_idx, tail_idx;
  logic              full;
  logic              alloc, retire, flush;
  logic              h_valid, h_done, h_fault;
  logic [XLEN-1:0]   h_pc, h_value;
  logic [AREG_W-1:0] h_areg;
  cmt_e              act;

  assign retire       = (act == CMT_RETIRE);
  assign flush        = (act == CMT_TRAP);
  assign disp_ready_o = !flush && (!full || retire);
  assign alloc        = disp_valid_i && disp_ready_o;
  assign disp_tag_o   = tail_idx;

  rob_ptr_ctrl #(
    .DEPTH (DEPTH),
    .IDX_W (IDX_W),
    .CNT_W (CNT_W)
  ) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .alloc_i  (alloc),
    .retire_i (retire),
    .flush_i  (flush),
    .head_o   (head_idx),
    .tail_o   (tail_idx),
    .full_o   (full)
  );

  rob_entry_array #(
    .DEPTH  (DEPTH),
    .IDX_W  (IDX_W),
    .XLEN   (XLEN),
    .AREG_W (AREG_W)
  ) u_slots (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush_i      (flush),
    .alloc_i      (alloc),
    .alloc_idx_i  (tail_idx),
    .alloc_pc_i   (disp_pc_i),
    .alloc_areg_i (disp_areg_i),
    .wb_en_i      (wb_valid_i),
    .wb_idx_i     (wb_tag_i),
    .wb_value_i   (wb_value_i),
    .wb_fault_i   (wb_fault_i),
    .retire_i     (retire),
    .head_idx_i   (head_idx),
    .src_idx_i    (src_tag_i),
    .head_valid_o (h_valid),
    .head_done_o  (h_done),
    .head_fault_o (h_fault),
    .head_pc_o    (h_pc),
    .head_areg_o  (h_areg),
    .head_value_o (h_value),
    .src_value_o  (src_value_o),
    .src_ready_o  (src_ready_o)
  );

  rob_commit_unit #(
    .XLEN   (XLEN),
    .AREG_W (AREG_W)
  ) u_commit (
    .head_valid_i (h_valid),
    .head_done_i  (h_done),
    .head_fault_i (h_fault),
    .head_pc_i    (h_pc),
    .head_areg_i  (h_areg),
    .head_value_i (h_value),
    .act_o        (act),
    .arf_we_o     (arf_we_o),
    .arf_areg_o   (arf_areg_o),
    .arf_value_o  (arf_value_o),
    .trap_o       (trap_o),
    .trap_pc_o    (trap_pc_o)
  );

endmodule

// File: rtl/rob_checker.sv
`timescale 1ns/1ps
module rob_checker #(
  parameter int DEPTH = 8,
  parameter int IDX_W = 3,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             disp_valid_i,
  input logic             disp_ready_o,
  input logic [IDX_W-1:0] disp_tag_o,
  input logic             arf_we_o,
  input logic             trap_o
);

  logic [CNT_W-1:0] occ;
  logic [IDX_W-1:0] exp_tag;
  logic             fire;

  assign fire = disp_valid_i && disp_ready_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ     <= '0;
      exp_tag <= '0;
    end else if (trap_o) begin
      occ     <= '0;
      exp_tag <= '0;
    end else begin
      occ <= occ + CNT_W'(fire) - CNT_W'(arf_we_o);
      if (fire) exp_tag <= (exp_tag == IDX_W'(DEPTH - 1)) ? '0 : exp_tag + 1'b1;
    end
  end

  assert_occ_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CNT_W'(DEPTH));

  assert_full_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == CNT_W'(DEPTH) && !arf_we_o) |-> !disp_ready_o);

  assert_room_accepts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (occ < CNT_W'(DEPTH) && !trap_o) |-> disp_ready_o);

  assert_tag_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    disp_tag_o == exp_tag);

  assert_empty_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == '0) |-> !(arf_we_o || trap_o));

  assert_single_outcome_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(arf_we_o && trap_o));

  assert_trap_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> !disp_ready_o);

  assert_trap_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |=> (!arf_we_o && !trap_o && disp_tag_o == '0));

endmodule

bind rob_core rob_checker #(
  .DEPTH (DEPTH),
  .IDX_W (IDX_W),
  .CNT_W (CNT_W)
) u_rob_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .disp_valid_i (disp_valid_i),
  .disp_ready_o (disp_ready_o),
  .disp_tag_o   (disp_tag_o),
  .arf_we_o     (arf_we_o),
  .trap_o       (trap_o)
);

// File: tb/test_rob_core.sv
`timescale 1ns/1ps
module test_rob_core;
  localparam int DEPTH  = 8;
  localparam int XLEN   = 32;
  localparam int AREG_W = 5;
  localparam int IDX_W  = 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rst_n;
  logic              disp_valid_i;
  logic [XLEN-1:0]   disp_pc_i;
  logic [AREG_W-1:0] disp_areg_i;
  logic              disp_ready_o;
  logic [IDX_W-1:0]  disp_tag_o;
  logic              wb_valid_i;
  logic [IDX_W-1:0]  wb_tag_i;
  logic [XLEN-1:0]   wb_value_i;
  logic              wb_fault_i;
  logic [IDX_W-1:0]  src_tag_i;
  logic [XLEN-1:0]   src_value_o;
  logic              src_ready_o;
  logic              arf_we_o;
  logic [AREG_W-1:0] arf_areg_o;
  logic [XLEN-1:0]   arf_value_o;
  logic              trap_o;
  logic [XLEN-1:0]   trap_pc_o;

  rob_core #(.DEPTH(DEPTH), .XLEN(XLEN), .AREG_W(AREG_W)) i_rob_core (
    .clk(clk), .rst_n(rst_n),
    .disp_valid_i(disp_valid_i), .disp_pc_i(disp_pc_i), .disp_areg_i(disp_areg_i),
    .disp_ready_o(disp_ready_o), .disp_tag_o(disp_tag_o),
    .wb_valid_i(wb_valid_i), .wb_tag_i(wb_tag_i), .wb_value_i(wb_value_i),
    .wb_fault_i(wb_fault_i), .src_tag_i(src_tag_i),
    .src_value_o(src_value_o), .src_ready_o(src_ready_o),
    .arf_we_o(arf_we_o), .arf_areg_o(arf_areg_o), .arf_value_o(arf_value_o),
    .trap_o(trap_o), .trap_pc_o(trap_pc_o)
  );

  int total = 0;
  int bad   = 0;
  string scn = "R1";

  // behavioural reference state
  int mh, mt, mcnt;
  bit mv [DEPTH];
  bit md [DEPTH];
  bit mf [DEPTH];
  logic [XLEN-1:0]   mpc  [DEPTH];
  logic [XLEN-1:0]   mval [DEPTH];
  logic [AREG_W-1:0] mar  [DEPTH];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp, input string what);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < DEPTH; i++) begin
      mv[i] = 1'b0; md[i] = 1'b0; mf[i] = 1'b0;
    end
    mh = 0; mt = 0; mcnt = 0;
  endtask

  // compare outputs against the reference, then advance one clock
  task automatic step();
    bit hd, e_arf, e_trap, e_rdy, e_sr;
    int h, st, wt;
    #1;
    h      = mh;
    hd     = (mcnt > 0) && mv[h] && md[h];
    e_arf  = hd && !mf[h];
    e_trap = hd && mf[h];
    e_rdy  = !e_trap && ((mcnt < DEPTH) || e_arf);
    st     = int'(src_tag_i);
    e_sr   = mv[st] && md[st];
    chk(disp_ready_o == e_rdy, {scn, " R3"}, 64'(disp_ready_o), 64'(e_rdy), "disp_ready");
    chk(disp_tag_o == IDX_W'(mt), {scn, " R2"}, 64'(disp_tag_o), 64'(mt), "disp_tag");
    chk(arf_we_o == e_arf, {scn, " R6"}, 64'(arf_we_o), 64'(e_arf), "arf_we");
    if (e_arf) begin
      chk(arf_areg_o == mar[h], {scn, " R6"}, 64'(arf_areg_o), 64'(mar[h]), "arf_areg");
      chk(arf_value_o == mval[h], {scn, " R6"}, 64'(arf_value_o), 64'(mval[h]), "arf_value");
    end
    chk(trap_o == e_trap, {scn, " R7"}, 64'(trap_o), 64'(e_trap), "trap");
    if (e_trap)
      chk(trap_pc_o == mpc[h], {scn, " R7"}, 64'(trap_pc_o), 64'(mpc[h]), "trap_pc");
    chk(src_ready_o == e_sr, {scn, " R4"}, 64'(src_ready_o), 64'(e_sr), "src_ready");
    if (e_sr)
      chk(src_value_o == mval[st], {scn, " R4"}, 64'(src_value_o), 64'(mval[st]), "src_value");
    @(posedge clk);
    if (e_trap) begin
      model_reset();
    end else begin
      wt = int'(wb_tag_i);
      if (wb_valid_i && mv[wt]) begin
        mval[wt] = wb_value_i; mf[wt] = wb_fault_i; md[wt] = 1'b1;
      end
      if (e_arf) begin
        mv[h] = 1'b0; mh = (mh + 1) % DEPTH; mcnt--;
      end
      if (disp_valid_i && e_rdy) begin
        mv[mt] = 1'b1; md[mt] = 1'b0; mf[mt] = 1'b0;
        mpc[mt] = disp_pc_i; mar[mt] = disp_areg_i;
        mt = (mt + 1) % DEPTH; mcnt++;
      end
    end
    @(negedge clk);
  endtask

  task automatic cyc(input bit dv, input logic [XLEN-1:0] pc, input logic [AREG_W-1:0] ar,
                     input bit wv, input int wt, input logic [XLEN-1:0] wval, input bit wf,
                     input int st);
    disp_valid_i = dv; disp_pc_i = pc; disp_areg_i = ar;
    wb_valid_i = wv; wb_tag_i = IDX_W'(wt); wb_value_i = wval; wb_fault_i = wf;
    src_tag_i = IDX_W'(st);
    step();
  endtask

  task automatic idle(input int st);
    cyc(1'b0, '0, '0, 1'b0, 0, '0, 1'b0, st);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    disp_valid_i = 1'b0; disp_pc_i = '0; disp_areg_i = '0;
    wb_valid_i = 1'b0; wb_tag_i = '0; wb_value_i = '0; wb_fault_i = 1'b0;
    src_tag_i = '0;
    model_reset();
    repeat (3) @(negedge clk);
    // R1: state while held in reset
    chk(disp_ready_o == 1'b1, "R1", 64'(disp_ready_o), 64'd1, "ready in reset");
    chk(arf_we_o == 1'b0 && trap_o == 1'b0, "R1", 64'(arf_we_o | trap_o), 64'd0, "commit in reset");
    rst_n = 1'b1;
    @(negedge clk);
    for (int t = 0; t < DEPTH; t++) begin
      src_tag_i = IDX_W'(t);
      #0.1;
      chk(src_ready_o == 1'b0, "R1", 64'(src_ready_o), 64'd0, "src ready after reset");
    end
    chk(disp_tag_o == '0, "R1", 64'(disp_tag_o), 64'd0, "first tag");

    // R2 R4 R5 R6: three dispatches, writebacks out of order
    scn = "R2";
    for (int i = 0; i < 3; i++) begin
      chk(disp_tag_o == IDX_W'(i), "R2", 64'(disp_tag_o), 64'(i), "sequential tag");
      cyc(1'b1, 32'h100 + 32'(4 * i), AREG_W'(i + 1), 1'b0, 0, '0, 1'b0, 0);
    end
    scn = "R4";
    cyc(1'b0, '0, '0, 1'b1, 2, 32'h22, 1'b0, 2);
    chk(src_ready_o == 1'b1 && src_value_o == 32'h22, "R4", 64'(src_value_o), 64'h22, "lookup after wb");
    chk(arf_we_o == 1'b0, "R5", 64'(arf_we_o), 64'd0, "younger done does not retire");
    scn = "R6";
    cyc(1'b0, '0, '0, 1'b1, 0, 32'h11, 1'b0, 1);
    chk(arf_we_o == 1'b1 && arf_areg_o == 5'd1 && arf_value_o == 32'h11, "R6",
        64'(arf_value_o), 64'h11, "head retire");
    cyc(1'b0, '0, '0, 1'b1, 1, 32'h33, 1'b0, 1);
    while (mcnt > 0) idle(2);

    // R3 R9: fill, refuse, then dispatch alongside a retirement
    scn = "R3";
    for (int i = 0; i < DEPTH; i++)
      cyc(1'b1, 32'h200 + 32'(4 * i), 5'd7, 1'b0, 0, '0, 1'b0, 3);
    chk(disp_ready_o == 1'b0, "R3", 64'(disp_ready_o), 64'd0, "full refuses");
    cyc(1'b1, 32'hDEAD, 5'd9, 1'b0, 0, '0, 1'b0, 3);
    chk(disp_tag_o == 3'd3, "R3", 64'(disp_tag_o), 64'd3, "refused dispatch ignored");
    scn = "R9";
    cyc(1'b0, '0, '0, 1'b1, 3, 32'hA3, 1'b0, 3);
    chk(disp_ready_o == 1'b1 && arf_we_o == 1'b1, "R9", 64'(disp_ready_o), 64'd1, "full with retire");
    cyc(1'b1, 32'h300, 5'd7, 1'b0, 0, '0, 1'b0, 3);
    chk(disp_ready_o == 1'b0 && disp_tag_o == 3'd4, "R9", 64'(disp_tag_o), 64'd4, "refilled");

    // R10: all slots name register 7, retire in order
    scn = "R10";
    for (int k = 0; k < DEPTH; k++)
      cyc(1'b0, '0, '0, 1'b1, (4 + k) % DEPTH, 32'hB0 + 32'(k), 1'b0, (4 + k) % DEPTH);
    while (mcnt > 0) idle(0);

    // R11: writeback into a free slot is dropped
    scn = "R11";
    cyc(1'b0, '0, '0, 1'b1, mt, 32'h55, 1'b0, mt);
    chk(src_ready_o == 1'b0, "R11", 64'(src_ready_o), 64'd0, "free slot not written");
    cyc(1'b1, 32'h400, 5'd4, 1'b0, 0, '0, 1'b0, mt);
    chk(src_ready_o == 1'b0, "R11", 64'(src_ready_o), 64'd0, "new slot unfinished");

    // R7 R8: fault on a younger slot, trapped only at the head
    scn = "R7";
    begin
      int b;
      b = (mt + DEPTH - 1) % DEPTH;
      cyc(1'b1, 32'h500, 5'd5, 1'b0, 0, '0, 1'b0, 0);
      cyc(1'b1, 32'h504, 5'd6, 1'b0, 0, '0, 1'b0, 0);
      cyc(1'b1, 32'h508, 5'd7, 1'b1, (b + 2) % DEPTH, 32'hEE, 1'b1, 0);
      chk(trap_o == 1'b0, "R7", 64'(trap_o), 64'd0, "non-head fault waits");
      cyc(1'b0, '0, '0, 1'b1, (b + 1) % DEPTH, 32'h61, 1'b0, 0);
      cyc(1'b0, '0, '0, 1'b1, b, 32'h60, 1'b0, (b + 3) % DEPTH);
      for (int g = 0; g < 6 && !trap_o; g++) idle((b + 3) % DEPTH);
      chk(trap_o == 1'b1 && trap_pc_o == 32'h504, "R7", 64'(trap_pc_o), 64'h504, "trap pc");
      chk(arf_we_o == 1'b0, "R7", 64'(arf_we_o), 64'd0, "no write on trap");
      chk(disp_ready_o == 1'b0, "R8", 64'(disp_ready_o), 64'd0, "dispatch refused in trap cycle");
      scn = "R8";
      cyc(1'b1, 32'h600, 5'd1, 1'b1, (b + 3) % DEPTH, 32'h77, 1'b0, (b + 3) % DEPTH);
      chk(disp_tag_o == '0, "R7", 64'(disp_tag_o), 64'd0, "tag restarts");
      chk(src_ready_o == 1'b0, "R7", 64'(src_ready_o), 64'd0, "younger squashed");
      chk(trap_o == 1'b0, "R7", 64'(trap_o), 64'd0, "single pulse");
    end

    // mixed traffic
    scn = "RND";
    for (int n = 0; n < 4000; n++) begin
      int wt;
      bit wf;
      wt = (($urandom % 8) < 7 && mcnt > 0) ? (mh + int'($urandom % mcnt)) % DEPTH
                                            : int'($urandom % DEPTH);
      wf = (($urandom % 24) == 0);
      cyc(($urandom % 3) != 0, $urandom, AREG_W'($urandom), ($urandom % 2) == 0,
          wt, $urandom, wf, int'($urandom % DEPTH));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule